// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache Controller

This block is a small data cache that sits between a word-addressed processor port and a slower main memory. It holds 32 data words as 4 sets of 2 ways, with 4-word lines. Tags, valid bits and one least-recently-used bit per set live in flip-flops. Each way's data lives in a simple dual-port RAM with a registered read port, so it can map onto block RAM.

A read that hits returns its word on the clock edge after it is accepted, the same timing as an uncached registered access. A read that misses raises `stall` for exactly five cycles. During that time the controller fetches the four words of the block from memory, one word per cycle, into the least recently used way of the set. The response comes on the edge where `stall` falls. Every write goes through to memory on the cycle after it is accepted. A write that hits also updates the cached word. A write that misses leaves the cache untouched. A free-running counter adds one for every stalled cycle, which comes to five per read miss, so software-free profiling can read miss cost directly.

Top module: `wt2_cache`

## Requirements
- R1: A read that hits (valid line in the set indexed by address bits [3:2] whose tag equals address bits [15:4]) gives `rsp_valid`=1 and the word at `rsp_rdata` one edge after acceptance, with `stall` staying 0.
- R2: A read that misses raises `stall` on the accepting edge and holds it for exactly 5 cycles. During the first 4 stalled cycles `mem_rd_en` is 1 and `mem_rd_addr` walks the block's words, starting at offset 0. `rsp_valid` with the requested word appears on the edge where `stall` falls.
- R3: The set index is address bits [3:2] and the word offset is bits [1:0]. Two different blocks can stay resident in one set, and sets do not disturb one another.
- R4: A read miss fills the least recently used way of its set, and the filled way becomes most recently used. A read hit or a write hit makes its way most recently used.
- R5: Every accepted write shows `mem_wr_en`=1 with the same address and data one edge after acceptance, whether it hits or misses. A later read of that address returns the written data.
- R6: A write hit also updates the cached word, so a following read hit returns the new value.
- R7: A write miss allocates no line and leaves the LRU state unchanged. A later read of that block misses. Writes never stall.
- R8: `stall_count` (32 bits) adds 1 on each cycle in which `stall` is 1, which is 5 per read miss. Hits and writes add nothing.
- R9: A request presented while `stall` is 1 is ignored: no memory write is issued and the fill length is unchanged.
- R10: Reset (synchronous, active high) invalidates every line, clears `stall_count`, and leaves `stall`, `rsp_valid` and `mem_wr_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, accepted when stall is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write data |
| stall | output | 1 | Cache busy filling a line; requests ignored |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| stall_count | output | 32 | Total stalled cycles since reset |
| mem_rd_en | output | 1 | Memory word read during a fill |
| mem_rd_addr | output | 16 | Memory word read address |
| mem_rd_data | input | 32 | Memory read data for mem_rd_addr, same cycle |
| mem_wr_en | output | 1 | Write-through strobe |
| mem_wr_addr | output | 16 | Write-through address |
| mem_wr_data | output | 32 | Write-through data |

## Verification
The bench drives several blocks through one set so that the victim choice decides which later reads hit. A design that evicted the most recently used way, or that forgot to refresh LRU on a write hit, then misses where a hit is expected, and the stall length exposes it. A write miss is followed by a read of the same block. A design that allocated on the write would hit there, and one that skipped the write-through would return stale data. A write presented during a fill checks that nothing reaches the memory port. A reset in the middle of a run checks that a block that was resident misses again and that the stall counter restarts from zero.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } wtc_state_e;

  typedef enum logic [1:0] {
    SRC_W0   = 2'd0,
    SRC_W1   = 2'd1,
    SRC_FILL = 2'd2
  } wtc_src_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic             hit_way,
  output logic             victim_way,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag
);
  import wtc_pkg::*;
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0]    tag_q   [NUM_WAYS][SETS];
  logic [NUM_WAYS-1:0] valid_q [SETS];
  logic [SETS-1:0]     lru_q;   // way to evict next
  logic [NUM_WAYS-1:0] hit_vec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[w][lk_set] == lk_tag);
  end

  assign hit        = |hit_vec;
  assign hit_way    = hit_vec[1];
  assign victim_way = lru_q[lk_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      lru_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_set][fill_way] <= 1'b1;
      lru_q[fill_set]             <= ~fill_way;
    end else if (touch_en) begin
      lru_q[touch_set] <= ~touch_way;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_way][fill_set] <= fill_tag;
  end

  // R3: a block is never resident in both ways of a set
  assert_one_way_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R4: a filled way becomes most recently used and valid
  assert_fill_mru_R4: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (lru_q[$past(fill_set)] != $past(fill_way)) &&
                valid_q[$past(fill_set)][$past(fill_way)]);
endmodule

// File: rtl/wtc_data_way.sv
module wtc_data_way #(
  parameter int AW     = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int OFF_W    = 2,
  parameter int IDX_W    = 2,
  parameter int MISS_LAT = 5,
  parameter int CNT_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     hit,
  input  logic                     hit_way,
  input  logic                     victim_way,
  output logic                     touch_en,
  output logic                     fill_en,
  output logic [IDX_W-1:0]         fill_set,
  output logic                     fill_way,
  output logic [ADDR_W-OFF_W-IDX_W-1:0] fill_tag,
  output logic [1:0]               dw_we,
  output logic [IDX_W+OFF_W-1:0]   dw_waddr,
  output logic [DATA_W-1:0]        dw_wdata,
  output logic                     rsp_valid,
  output wtc_pkg::wtc_src_e        rsp_src,
  output logic [DATA_W-1:0]        fill_word,
  output logic                     stall,
  output logic [CNT_W-1:0]         stall_count,
  output logic                     mem_rd_en,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic [DATA_W-1:0]        mem_rd_data,
  output logic                     mem_wr_en,
  output logic [ADDR_W-1:0]        mem_wr_addr,
  output logic [DATA_W-1:0]        mem_wr_data
);
  import wtc_pkg::*;
  localparam int WORDS = 1 << OFF_W;
  localparam int AW    = IDX_W + OFF_W;
  localparam int CW    = $clog2(MISS_LAT);
  localparam logic [CW-1:0] LAST   = CW'(MISS_LAT - 1);
  localparam logic [CW-1:0] NWORDS = CW'(WORDS);

  wtc_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic              victim_q;
  logic              acc, rd_hit, rd_miss, wr_acc, word_phase;

  assign acc        = req_valid && (state_q == ST_IDLE);
  assign rd_hit     = acc && !req_write && hit;
  assign rd_miss    = acc && !req_write && !hit;
  assign wr_acc     = acc && req_write;
  assign word_phase = (state_q == ST_FILL) && (cnt_q < NWORDS);

  assign touch_en = rd_hit || (wr_acc && hit);
  assign fill_en  = (state_q == ST_FILL) && (cnt_q == LAST);
  assign fill_set = miss_addr_q[AW-1:OFF_W];
  assign fill_tag = miss_addr_q[ADDR_W-1:AW];
  assign fill_way = victim_q;
  assign stall    = (state_q == ST_FILL);

  assign mem_rd_en   = word_phase;
  assign mem_rd_addr = {miss_addr_q[ADDR_W-1:OFF_W], cnt_q[OFF_W-1:0]};

  always_comb begin
    dw_we    = '0;
    dw_waddr = req_addr[AW-1:0];
    dw_wdata = req_wdata;
    if (state_q == ST_FILL) begin
      dw_waddr = {miss_addr_q[AW-1:OFF_W], cnt_q[OFF_W-1:0]};
      dw_wdata = mem_rd_data;
      if (word_phase) dw_we[victim_q] = 1'b1;
    end else if (wr_acc && hit) begin
      dw_we[hit_way] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      miss_addr_q <= '0;
      victim_q    <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_src     <= SRC_W0;
      fill_word   <= '0;
      stall_count <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_wr_en <= 1'b0;
      if (state_q == ST_FILL) stall_count <= stall_count + CNT_W'(1);
      case (state_q)
        ST_IDLE: begin
          if (rd_hit) begin
            rsp_valid <= 1'b1;
            rsp_src   <= hit_way ? SRC_W1 : SRC_W0;
          end
          if (rd_miss) begin
            state_q     <= ST_FILL;
            cnt_q       <= '0;
            miss_addr_q <= req_addr;
            victim_q    <= victim_way;
          end
          if (wr_acc) begin
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= req_addr;
            mem_wr_data <= req_wdata;
          end
        end
        ST_FILL: begin
          cnt_q <= cnt_q + CW'(1);
          if (word_phase && (cnt_q[OFF_W-1:0] == miss_addr_q[OFF_W-1:0]))
            fill_word <= mem_rd_data;
          if (cnt_q == LAST) begin
            state_q   <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_src   <= SRC_FILL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  initial begin
    assert (MISS_LAT > WORDS) else $error("miss latency must exceed line length");
  end

  // R5: each accepted write reaches the memory port next cycle unchanged
  assert_wr_through_R5: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> mem_wr_en && (mem_wr_addr == $past(req_addr)) &&
               (mem_wr_data == $past(req_wdata)));

  // R2: a read miss starts a fill with the memory read port active
  assert_fill_start_R2: assert property (@(posedge clk) disable iff (rst)
    rd_miss |=> stall && mem_rd_en);

  // R2: the last fill cycle ends the stall with a response
  assert_fill_end_R2: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> !stall && rsp_valid);

  // R8: the counter grows by one per stalled cycle and holds otherwise
  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    stall |=> stall_count == $past(stall_count) + CNT_W'(1));
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !stall |=> $stable(stall_count));

  // R9: nothing is written to memory while stalled
  assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    stall |=> !mem_wr_en);
endmodule

// File: rtl/wt2_cache.sv
module wt2_cache #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int OFF_W    = 2,
  parameter int IDX_W    = 2,
  parameter int MISS_LAT = 5,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              stall,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [CNT_W-1:0]  stall_count,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  import wtc_pkg::*;
  localparam int AW    = IDX_W + OFF_W;
  localparam int TAG_W = ADDR_W - AW;

  logic              hit, hit_way, victim_way, touch_en;
  logic              fill_en, fill_way;
  logic [IDX_W-1:0]  fill_set;
  logic [TAG_W-1:0]  fill_tag;
  logic [1:0]        dw_we;
  logic [AW-1:0]     dw_waddr;
  logic [DATA_W-1:0] dw_wdata, fill_word;
  logic [DATA_W-1:0] way_rdata [NUM_WAYS];
  wtc_src_e          rsp_src;

  wtc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .lk_set(req_addr[AW-1:OFF_W]), .lk_tag(req_addr[ADDR_W-1:AW]),
    .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
    .touch_en(touch_en), .touch_set(req_addr[AW-1:OFF_W]), .touch_way(hit_way),
    .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    wtc_data_way #(.AW(AW), .DATA_W(DATA_W)) u_data (
      .clk(clk), .we(dw_we[w]), .waddr(dw_waddr), .wdata(dw_wdata),
      .raddr(req_addr[AW-1:0]), .rdata(way_rdata[w])
    );
  end

  wtc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .MISS_LAT(MISS_LAT), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
    .touch_en(touch_en), .fill_en(fill_en), .fill_set(fill_set),
    .fill_way(fill_way), .fill_tag(fill_tag),
    .dw_we(dw_we), .dw_waddr(dw_waddr), .dw_wdata(dw_wdata),
    .rsp_valid(rsp_valid), .rsp_src(rsp_src), .fill_word(fill_word),
    .stall(stall), .stall_count(stall_count),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  always_comb begin
    case (rsp_src)
      SRC_W1:   rsp_rdata = way_rdata[1];
      SRC_FILL: rsp_rdata = fill_word;
      default:  rsp_rdata = way_rdata[0];
    endcase
  end

  // R1: a read hit never stalls and answers on the next edge
  assert_hit_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !stall && hit) |=> rsp_valid && !stall);
endmodule

// File: tb/wt2_cache_bench.sv
module wt2_cache_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        stall, rsp_valid, mem_rd_en, mem_wr_en;
  logic [31:0] rsp_rdata, stall_count, mem_rd_data, mem_wr_data;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [31:0] bmem [1024];
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;

  wt2_cache u_wt2_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .stall(stall),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .stall_count(stall_count),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  assign mem_rd_data = bmem[mem_rd_addr[9:0]];
  always @(posedge clk) if (mem_wr_en) bmem[mem_wr_addr[9:0]] <= mem_wr_data;

  // {write, addr, wdata, expect_miss, requirement id}
  localparam logic [53:0] VEC [21] = '{
    {1'b0, 16'h0000, 32'h0,         1'b1, 4'd2},
    {1'b0, 16'h0001, 32'h0,         1'b0, 4'd1},
    {1'b0, 16'h0003, 32'h0,         1'b0, 4'd1},
    {1'b0, 16'h0040, 32'h0,         1'b1, 4'd3},
    {1'b0, 16'h0042, 32'h0,         1'b0, 4'd1},
    {1'b0, 16'h0002, 32'h0,         1'b0, 4'd1},
    {1'b0, 16'h0080, 32'h0,         1'b1, 4'd4},
    {1'b0, 16'h0001, 32'h0,         1'b0, 4'd4},
    {1'b0, 16'h0041, 32'h0,         1'b1, 4'd4},
    {1'b1, 16'h0081, 32'h1111_1111, 1'b1, 4'd7},
    {1'b0, 16'h0081, 32'h0,         1'b1, 4'd7},
    {1'b1, 16'h0042, 32'h2222_2222, 1'b0, 4'd6},
    {1'b0, 16'h0003, 32'h0,         1'b1, 4'd4},
    {1'b0, 16'h0042, 32'h0,         1'b0, 4'd6},
    {1'b1, 16'h00C0, 32'h3333_3333, 1'b1, 4'd7},
    {1'b0, 16'h00C0, 32'h0,         1'b1, 4'd7},
    {1'b0, 16'h0002, 32'h0,         1'b1, 4'd4},
    {1'b0, 16'h00C1, 32'h0,         1'b0, 4'd4},
    {1'b0, 16'h0044, 32'h0,         1'b1, 4'd3},
    {1'b0, 16'h0047, 32'h0,         1'b0, 4'd3},
    {1'b0, 16'h0081, 32'h0,         1'b1, 4'd5}
  };

  function automatic string rname(int k);
    case (k)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // wait out a stall that is visible now; returns its length
  task automatic wait_fill(string req, logic [15:0] a, output int n);
    n = 0;
    chk(mem_rd_en && (mem_rd_addr == {a[15:2], 2'b00}), req, "fill start addr",
        {16'h0, mem_rd_addr}, {16'h0, a[15:2], 2'b00});
    while (stall && n < 20) begin
      n++;
      chk(!mem_wr_en, "R9", "write during stall", {31'h0, mem_wr_en}, 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic access(bit wr, logic [15:0] a, logic [31:0] d, bit miss, string req);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      chk(mem_wr_en && mem_wr_addr == a, "R5", "write-through addr", {16'h0, mem_wr_addr}, {16'h0, a});
      chk(mem_wr_data == d, "R5", "write-through data", mem_wr_data, d);
      chk(!stall && !rsp_valid, req, "write stall/rsp", {30'h0, stall, rsp_valid}, 32'h0);
    end else if (!miss) begin
      chk(!stall && rsp_valid, req, "hit handshake", {30'h0, stall, rsp_valid}, 32'h1);
      chk(rsp_rdata == bmem[a[9:0]], req, "hit data", rsp_rdata, bmem[a[9:0]]);
    end else begin
      chk(stall, req, "miss stall", {31'h0, stall}, 32'h1);
      wait_fill(req, a, n);
      chk(n == 5, req, "stall length", n, 5);
      chk(rsp_valid && rsp_rdata == bmem[a[9:0]], req, "miss data", rsp_rdata, bmem[a[9:0]]);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 32'hC0DE_0000 | i;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(!stall && !rsp_valid && !mem_wr_en, "R10", "outputs after reset",
        {29'h0, stall, rsp_valid, mem_wr_en}, 32'h0);
    chk(stall_count == 0, "R10", "counter after reset", stall_count, 0);

    for (int v = 0; v < 21; v++)
      access(VEC[v][53], VEC[v][52:37], VEC[v][36:5], VEC[v][4], rname(int'(VEC[v][3:0])));

    // R8: ten read misses so far
    chk(stall_count == 50, "R8", "stall total", stall_count, 50);

    // R9: a write held during a fill is ignored
    begin
      int n;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0100;
      @(negedge clk);
      req_write = 1'b1; req_addr = 16'h0200; req_wdata = 32'hDEAD_BEEF;
      chk(stall, "R9", "miss stall", {31'h0, stall}, 32'h1);
      req_addr = 16'h0100; req_write = 1'b0;
      req_write = 1'b1; req_addr = 16'h0200;
      n = 0;
      while (stall && n < 20) begin
        n++;
        chk(!mem_wr_en, "R9", "write during stall", {31'h0, mem_wr_en}, 32'h0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(n == 5, "R9", "stall length", n, 5);
      chk(rsp_valid && rsp_rdata == bmem[10'h100], "R9", "fill data", rsp_rdata, bmem[10'h100]);
      @(negedge clk);
      chk(bmem[10'h200] == 32'hC0DE_0200, "R9", "ignored write", bmem[10'h200], 32'hC0DE_0200);
      chk(stall_count == 55, "R8", "stall total", stall_count, 55);
    end

    // R10: reset invalidates a resident line and clears the counter
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk(stall_count == 0 && !stall, "R10", "counter after reset", stall_count, 0);
    access(1'b0, 16'h00C1, 32'h0, 1'b1, "R10");
    chk(stall_count == 5, "R8", "count after one miss", stall_count, 5);
    access(1'b0, 16'h00C2, 32'h0, 1'b0, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule